// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block walks a chain of command packets stored in a 2 MB word-organised memory and delivers their payloads to a command sink. Each node starts with a 32-bit header word. The top byte of the header gives the payload length in words. The low 24 bits give the link to the next node. The payload words sit directly after the header. The walker reads the header, streams the payload words one by one over a valid/ready handshake, and then follows the link. It stops when it meets a link whose bit 23 is set. While it runs, it adds up the transfer cost charged for the chain.

A client loads a start address and pulses `go`. `busy` stays high for the whole walk, and a one-cycle `done` pulse ends it. The final cost total and the last link remain readable at the outputs until the next walk starts. A step mode stops the walk after one node, so the client can see the following link. A node limit stops a chain that never terminates and raises `error`.

The control is a single state machine:
- `WS_IDLE` waits for `go` (*start*).
- `WS_LINK` inspects the current link. It takes *terminate* to `WS_DONE` on bit 23, *abort* to `WS_DONE` when the node limit is reached, and otherwise *header read* to `WS_HEAD`.
- `WS_HEAD` captures the header. It takes *empty node* back to `WS_LINK`, or to `WS_DONE` in step mode. It takes *payload* to `WS_FETCH`.
- `WS_FETCH` issues a payload read and moves to `WS_LOAD`.
- `WS_LOAD` captures the word and moves to `WS_SEND`.
- `WS_SEND` holds the word until the sink accepts it. It then takes *next word* to `WS_FETCH`, or *node end* to `WS_LINK`, or to `WS_DONE` in step mode.
- `WS_DONE` pulses `done` and returns to `WS_IDLE`.

Top module: `chain_walker`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `cmd_valid` and `mem_rd` are 0, and `cycle_total` and `next_link` are 0.
- R2: On `go`, the start address is masked to its low 24 bits. If its bit 23 is clear, the first memory read comes in the cycle after `go`, at word address `start_addr[20:2]`. Bits 31:24, 22:21 and 1:0 have no effect on that address.
- R3: A header word is read at word address `link[20:2]`. Its bits 31:24 are the payload length and its bits 23:0 are the next link. The payload words are read from the following consecutive word addresses, which wrap modulo 2^19 words.
- R4: Payload words reach `cmd_data` in memory order. `cmd_valid` and `cmd_data` hold unchanged while `cmd_ready` is low, and each word is handed over exactly once.
- R5: No memory read is issued while a payload word waits on a low `cmd_ready`, and `mem_rd` and `cmd_valid` are never high together.
- R6: A node whose length field is 0 delivers no word to the sink, but it is still counted and its link is followed.
- R7: The walk ends when the current link has bit 23 set. `done` is then high for exactly one cycle, and `busy` is low in the next cycle.
- R8: `cycle_total` is cleared on `go`. It grows by 10 for every header read, and by a further 5 plus the length for a header with a nonzero length. It holds its value after `done`.
- R9: When `step_mode` is high at `go`, the walk stops after one node, and `next_link` shows that node's link field. After any walk, `next_link` shows the link that ended it.
- R10: After `max_nodes` headers have been read without reaching a terminator, the walk stops with a `done` pulse and `error` set to 1. `error` is cleared by the next `go`.
- R11: A `go` that arrives while `busy` is high is ignored. The running walk, its payload stream and its total are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, taken only when idle |
| start_addr | input | 32 | Link of the first node (masked to 24 bits) |
| step_mode | input | 1 | Stop after one node, sampled at `go` |
| max_nodes | input | NODE_W | Node limit, sampled at `go` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| error | output | 1 | Walk ended by the node limit |
| next_link | output | 24 | Current or final link |
| cycle_total | output | TOTAL_W | Accumulated transfer cost |
| mem_rd | output | 1 | Memory read strobe; data returns one cycle later |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_rdata | input | 32 | Memory read data |
| cmd_valid | output | 1 | Payload word valid |
| cmd_data | output | 32 | Payload word |
| cmd_ready | input | 1 | Sink accepts the word |

## Verification
The assertions take for granted that the memory returns the addressed word exactly one cycle after `mem_rd`. They also take for granted that `start_addr`, `step_mode` and `max_nodes` matter only in the `go` cycle, and that the sink may drop `cmd_ready` at any time. The bench models the memory with exactly that one-cycle latency. It changes the configuration inputs only at the `go` edge or while the walker is idle, apart from a deliberate second `go` during a walk. It lets `cmd_ready` toggle freely at random, at several acceptance rates.

// File: rtl/chain_walk_pkg.sv
`timescale 1ns/1ps
package chain_walk_pkg;

    localparam int WORD_W = 32;
    localparam int LINK_W = 24;
    localparam int LEN_W  = WORD_W - LINK_W;
    localparam int END_BIT = LINK_W - 1;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_LINK,
        WS_HEAD,
        WS_FETCH,
        WS_LOAD,
        WS_SEND,
        WS_DONE
    } walk_state_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [LINK_W-1:0] link;
    } chain_hdr_t;

endpackage

// File: rtl/chain_cost_acc.sv
`timescale 1ns/1ps
module chain_cost_acc #(
    parameter int TOTAL_W   = 32,
    parameter int LEN_W     = 8,
    parameter int NODE_COST = 10,
    parameter int LEN_COST  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               add_en,
    input  logic [LEN_W-1:0]   len,
    output logic [TOTAL_W-1:0] total
);

    logic [TOTAL_W-1:0] total_q;
    logic [TOTAL_W-1:0] charge;

    // every node pays the fixed cost; a node carrying payload pays more
    always_comb begin
        charge = TOTAL_W'(NODE_COST);
        if (len != '0) begin
            charge = charge + TOTAL_W'(LEN_COST) + TOTAL_W'(len);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (clear) begin
            total_q <= '0;
        end else if (add_en) begin
            total_q <= total_q + charge;
        end
    end

    assign total = total_q;

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (total_q == '0));

    p_hold_total_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !add_en) |=> $stable(total_q));

endmodule

// File: rtl/chain_node_guard.sv
`timescale 1ns/1ps
module chain_node_guard #(
    parameter int NODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [NODE_W-1:0] limit_in,
    input  logic              count_en,
    output logic              at_limit
);

    logic [NODE_W-1:0] cnt_q;
    logic [NODE_W-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
            lim_q <= limit_in;
        end else if (count_en && (cnt_q != lim_q)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == lim_q);

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);

    p_limit_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> $stable(lim_q));

endmodule

// File: rtl/chain_walker.sv
`timescale 1ns/1ps
module chain_walker
    import chain_walk_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int NODE_W    = 16,
    parameter int TOTAL_W   = 32,
    parameter int NODE_COST = 10,
    parameter int LEN_COST  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [31:0]         start_addr,
    input  logic                step_mode,
    input  logic [NODE_W-1:0]   max_nodes,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic [23:0]         next_link,
    output logic [TOTAL_W-1:0]  cycle_total,
    output logic                mem_rd,
    output logic [ADDR_W-3:0]   mem_addr,
    input  logic [31:0]         mem_rdata,
    output logic                cmd_valid,
    output logic [31:0]         cmd_data,
    input  logic                cmd_ready
);

    localparam int WADDR_W = ADDR_W - 2;

    walk_state_e          state_q, state_d;
    logic [LINK_W-1:0]    link_q;
    logic [WADDR_W-1:0]   ptr_q;
    logic [LEN_W-1:0]     remain_q;
    logic [WORD_W-1:0]    word_q;
    logic                 step_q;
    logic                 err_q;
    logic                 at_limit;
    logic                 start_walk;
    logic                 node_seen;
    logic                 unused_hi;
    chain_hdr_t           hdr;

    assign unused_hi  = ^start_addr[31:LINK_W];
    assign hdr        = chain_hdr_t'(mem_rdata);
    assign start_walk = (state_q == WS_IDLE) && go;
    assign node_seen  = (state_q == WS_HEAD);

    chain_cost_acc #(
        .TOTAL_W   (TOTAL_W),
        .LEN_W     (LEN_W),
        .NODE_COST (NODE_COST),
        .LEN_COST  (LEN_COST)
    ) u_cost (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_walk),
        .add_en (node_seen),
        .len    (hdr.len),
        .total  (cycle_total)
    );

    chain_node_guard #(
        .NODE_W (NODE_W)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_walk),
        .limit_in (max_nodes),
        .count_en (node_seen),
        .at_limit (at_limit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (go) state_d = WS_LINK;
            WS_LINK: begin
                if (link_q[END_BIT])  state_d = WS_DONE;
                else if (at_limit)    state_d = WS_DONE;
                else                  state_d = WS_HEAD;
            end
            WS_HEAD: begin
                if (hdr.len == '0) state_d = step_q ? WS_DONE : WS_LINK;
                else               state_d = WS_FETCH;
            end
            WS_FETCH: state_d = WS_LOAD;
            WS_LOAD:  state_d = WS_SEND;
            WS_SEND: begin
                if (cmd_ready) begin
                    if (remain_q == LEN_W'(1)) state_d = step_q ? WS_DONE : WS_LINK;
                    else                       state_d = WS_FETCH;
                end
            end
            WS_DONE:  state_d = WS_IDLE;
            default:  state_d = WS_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q   <= '0;
            ptr_q    <= '0;
            remain_q <= '0;
            word_q   <= '0;
            step_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                WS_IDLE: begin
                    if (go) begin
                        link_q <= start_addr[LINK_W-1:0];
                        step_q <= step_mode;
                        err_q  <= 1'b0;
                    end
                end
                WS_LINK: begin
                    ptr_q <= link_q[ADDR_W-1:2];
                    if (!link_q[END_BIT] && at_limit) err_q <= 1'b1;
                end
                WS_HEAD: begin
                    link_q   <= hdr.link;
                    remain_q <= hdr.len;
                    ptr_q    <= ptr_q + 1'b1;
                end
                WS_LOAD: word_q <= mem_rdata;
                WS_SEND: begin
                    if (cmd_ready) begin
                        ptr_q    <= ptr_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                    end
                end
                WS_FETCH, WS_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        done      = 1'b0;
        mem_rd    = 1'b0;
        cmd_valid = 1'b0;
        mem_addr  = ptr_q;
        unique case (state_q)
            WS_IDLE:  busy = 1'b0;
            WS_LINK: begin
                mem_addr = link_q[ADDR_W-1:2];
                mem_rd   = !link_q[END_BIT] && !at_limit;
            end
            WS_HEAD:  ;
            WS_FETCH: mem_rd = 1'b1;
            WS_LOAD:  ;
            WS_SEND:  cmd_valid = 1'b1;
            WS_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign cmd_data  = word_q;
    assign next_link = link_q;
    assign error     = err_q;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_valid && !mem_rd && !done));

    p_hold_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    p_no_read_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> !mem_rd);

    p_read_send_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && cmd_valid));

    p_payload_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && remain_q != LEN_W'(1)) |=>
            (mem_rd && mem_addr == WADDR_W'($past(ptr_q) + 1'b1)));

    p_term_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !cmd_valid && !mem_rd && link_q[END_BIT] && state_q == WS_LINK)
            |=> done);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);

endmodule

// File: tb/tb_chain_walker.sv
`timescale 1ns/1ps
module tb_chain_walker;

    localparam int NW = 16;
    localparam int TW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            go = 1'b0;
    logic [31:0]     start_addr = '0;
    logic            step_mode = 1'b0;
    logic [NW-1:0]   max_nodes = '0;
    logic            busy, done, error;
    logic [23:0]     next_link;
    logic [TW-1:0]   cycle_total;
    logic            mem_rd;
    logic [18:0]     mem_addr;
    logic [31:0]     mem_rdata = '0;
    logic            cmd_valid;
    logic [31:0]     cmd_data;
    logic            cmd_ready = 1'b0;

    int              n_total = 0;
    int              n_bad = 0;
    int              ready_pct = 100;
    int              cyc = 0;
    logic [31:0]     mem [int unsigned];
    logic [31:0]     exp_q [$];

    chain_walker dut (
        .clk(clk), .rst_n(rst_n), .go(go), .start_addr(start_addr),
        .step_mode(step_mode), .max_nodes(max_nodes), .busy(busy),
        .done(done), .error(error), .next_link(next_link),
        .cycle_total(cycle_total), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] rd(input int unsigned a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= rd({13'b0, mem_addr});
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        cmd_ready = ($urandom_range(99) < ready_pct);
        if (rst_n && mem_rd && cmd_valid) begin
            n_total++; n_bad++;
            $display("FAIL R5 read beside waiting word actual=1 expected=0");
        end
        if (rst_n && cmd_valid && cmd_ready) begin
            if (exp_q.size() == 0) begin
                n_total++; n_bad++;
                $display("FAIL R4 extra word actual=%0h expected=none", cmd_data);
            end else begin
                chk("R4 payload word", {32'h0, cmd_data}, {32'h0, exp_q.pop_front()});
            end
        end
        if (cyc > 150000) begin
            n_total++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    // expected behaviour from the requirements: R3, R6, R8, R9, R10
    task automatic ref_walk(input logic [31:0] s, input bit st, input int mx,
                            output logic [31:0] tot, output logic [23:0] lnk, output bit er);
        logic [23:0] l;
        logic [31:0] h;
        int unsigned w;
        int len;
        int n;
        l = s[23:0]; n = 0; tot = 0; er = 0;
        while (1) begin
            if (l[23]) break;
            if (n == mx) begin er = 1; break; end
            w = {13'b0, l[20:2]};
            h = rd(w);
            len = int'(h[31:24]);
            n++;
            tot += 10;
            if (len != 0) tot += 5 + len;
            for (int i = 1; i <= len; i++) exp_q.push_back(rd((w + i) & 32'h7FFFF));
            l = h[23:0];
            if (st) break;
        end
        lnk = l;
    endtask

    task automatic run_walk(input logic [31:0] s, input bit st, input int mx, input bit mid,
                            output logic [23:0] lnk_out);
        logic [31:0] et;
        logic [23:0] el;
        bit ee;
        int waitc;
        exp_q.delete();
        ref_walk(s, st, mx, et, el, ee);
        lnk_out = el;
        @(negedge clk);
        start_addr = s; step_mode = st; max_nodes = NW'(mx); go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        if (!s[23] && mx != 0)
            chk("R2 first header address", {43'h0, mem_rd, mem_addr}, {43'h0, 1'b1, s[20:2]});
        if (mid) begin
            start_addr = 32'h0000_0100; step_mode = 1'b1; max_nodes = NW'(1); go = 1'b1;
            @(negedge clk);
            go = 1'b0;
            chk("R11 busy after second go", {63'h0, busy}, 64'h1);
        end
        waitc = 0;
        while (!done && waitc < 20000) begin
            @(negedge clk);
            waitc++;
        end
        if (!done) begin
            n_total++; n_bad++;
            $display("FAIL R7 no done actual=0 expected=1");
            return;
        end
        chk("R8 cycle total", {32'h0, cycle_total}, {32'h0, et});
        chk("R9 final link", {40'h0, next_link}, {40'h0, el});
        chk("R10 error flag", {63'h0, error}, {63'h0, ee});
        chk("R6 all words delivered", 64'(exp_q.size()), 64'h0);
        @(negedge clk);
        chk("R7 idle after done", {62'h0, busy, done}, 64'h0);
    endtask

    task automatic build_list(input int unsigned base, input int n, input int maxlen,
                              output logic [31:0] start);
        int unsigned cur;
        int unsigned nxt;
        int len;
        int nlen;
        logic [31:0] r;
        logic [23:0] link;
        cur = base;
        len = $urandom_range(maxlen);
        r = $urandom;
        start = {r[31:24], 1'b0, r[22:21], cur[18:0], r[1:0]};
        for (int i = 0; i < n; i++) begin
            nlen = $urandom_range(maxlen);
            nxt = cur + 1 + len + $urandom_range(3);
            r = $urandom;
            if (i == n - 1) link = {1'b1, r[22:0]};
            else            link = {1'b0, r[22:21], nxt[18:0], r[1:0]};
            mem[cur] = {8'(len), link};
            for (int k = 1; k <= len; k++) mem[cur + k] = $urandom;
            cur = nxt;
            len = nlen;
        end
    endtask

    initial begin
        logic [31:0] s;
        logic [23:0] lk;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 reset flags", {59'h0, busy, done, error, cmd_valid, mem_rd}, 64'h0);
        chk("R1 reset total and link", {cycle_total, 8'h0, next_link}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 terminator at the start: no node, zero total
        run_walk(32'h0080_1234, 1'b0, 100, 1'b0, lk);

        // R2 masking of upper and lower junk bits, one node of two words
        mem.delete();
        mem[32'h10] = {8'd2, 24'h80_0000};
        mem[32'h11] = 32'hA1A1_0001;
        mem[32'h12] = 32'hB2B2_0002;
        run_walk(32'hFF60_0043, 1'b0, 100, 1'b0, lk);

        // R6 empty nodes in a chain
        mem.delete();
        mem[32'h20] = {8'd0, 24'h00_0084};
        mem[32'h21] = {8'd3, 24'h00_0100};
        mem[32'h22] = 32'h1; mem[32'h23] = 32'h2; mem[32'h24] = 32'h3;
        mem[32'h40] = {8'd0, 24'h80_0000};
        run_walk(32'h0000_0080, 1'b0, 100, 1'b0, lk);

        // R3 payload address wraps at the top of memory
        mem.delete();
        mem[32'h7FFFE] = {8'd3, 24'h00_0020};
        mem[32'h7FFFF] = 32'hCAFE_0001;
        mem[32'h0]     = 32'hCAFE_0002;
        mem[32'h1]     = 32'hCAFE_0003;
        mem[32'h8]     = {8'd1, 24'h80_0000};
        mem[32'h9]     = 32'hCAFE_0004;
        ready_pct = 50;
        run_walk(32'h001F_FFF8, 1'b0, 100, 1'b0, lk);

        // R9 step mode through a three-node list
        mem.delete();
        build_list(32'h300, 3, 4, s);
        for (int i = 0; i < 4; i++) begin
            run_walk(s, 1'b1, 100, 1'b0, lk);
            s = {8'h0, lk};
        end

        // R10 self-looping node stopped by the limit, then error cleared
        mem.delete();
        mem[32'h100] = {8'd1, 24'h00_0400};
        mem[32'h101] = 32'h5555_AAAA;
        run_walk(32'h0000_0400, 1'b0, 4, 1'b0, lk);
        build_list(32'h500, 2, 3, s);
        run_walk(s, 1'b0, 100, 1'b0, lk);
        // R10 limit of one node on a longer list
        run_walk(s, 1'b0, 1, 1'b0, lk);

        // R11 second go during a long walk is ignored
        mem.delete();
        build_list(32'h800, 6, 8, s);
        ready_pct = 20;
        run_walk(s, 1'b0, 100, 1'b1, lk);

        // R4 random lists with varied sink readiness
        for (int t = 0; t < 30; t++) begin
            mem.delete();
            ready_pct = (t % 3 == 0) ? 100 : ((t % 3 == 1) ? 60 : 15);
            build_list($urandom_range(32'h7000), $urandom_range(1, 6), 7, s);
            run_walk(s, 1'b0, 100, 1'b0, lk);
        end

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule